// File: doc/BRIEF.md
# Microcoded Action Sequencer

This block is the control half of a small controlled machine. A micro-program counter selects one word from a control store. Each word carries three fields: an action code, an operand, and a jump target. When a word names an action (move forward, move back, or rotate), the sequencer raises a one-cycle strobe together with the action code and the operand. It then waits until the controlled datapath reports completion. When a word is a jump or a conditional branch, a next-address multiplexer selects either the incremented micro-PC or the word's target field. No action is issued for these words.

The control store holds a fixed patrol program:

| Address | Word |
|---|---|
| 0 | forward 35 |
| 1 | go to 0 while the path is clear |
| 2 | back 10 |
| 3 | rotate 90 |
| 4 | jump to 1 |

Any unused address holds a jump to 0. The datapath that acts on the strobes is outside this block. The control store is read through a register, in the style of a synchronous ROM.

Top module: `useq_ctrl`

## Requirements
- R1: A synchronous active-high reset sets the micro-PC output to 0 and clears the strobe. The first action after reset is forward (kind code 0) with operand 35, reported at micro-PC 0.
- R2: The action strobe is high for exactly one cycle per action word. The action kind and operand stay stable from the strobe until completion is accepted. Kind codes are: forward 0, back 1, rotate 2.
- R3: After issuing an action, the sequencer holds its micro-PC and issues nothing more until `act_done` is seen high while it is waiting.
- R4: A conditional branch word (code 3) taken while `path_clear` is 1 goes to its target. With the path clear, forward 35 therefore repeats at micro-PC 0.
- R5: A conditional branch with `path_clear` at 0 falls through to micro-PC plus one. Forward 35 is then followed by back 10 at micro-PC 2.
- R6: An unconditional jump word (code 4) goes to its target whatever `path_clear` is. After rotate 90 the program continues at address 1, so the next action depends only on `path_clear` at that branch.
- R7: `act_done` has no effect outside the waiting phase. A completion held high through fetch and decode of later words does not complete the next action.
- R8: `upc` shows the address of the word being executed: 0 for forward, 2 for back, 3 for rotate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| path_clear | input | 1 | Status flag tested by the conditional branch |
| act_done | input | 1 | Completion report from the controlled datapath |
| act_stb | output | 1 | One-cycle action issue strobe |
| act_kind | output | 3 | Action code of the issued action |
| act_arg | output | ARG_W | Operand of the issued action |
| upc | output | ADDR_W | Current micro-program counter |

## Verification
The assertions assume that `act_done` is only a meaningful completion while an action is outstanding. They also assume that `path_clear` is settled before each clock edge. The bench drives both inputs at the falling edge. It raises `act_done` for a single cycle after each observed strobe, except in one deliberate case where completion is held high across fetch and decode to show that it is ignored there. It changes `path_clear` only between actions, so each branch sees a known value.

// File: rtl/useq_pkg.sv
package useq_pkg;
  typedef enum logic [2:0] {
    UOP_FWD      = 3'd0,
    UOP_BACK     = 3'd1,
    UOP_TURN     = 3'd2,
    UOP_BR_CLEAR = 3'd3,
    UOP_JUMP     = 3'd4
  } uop_e;

  typedef enum logic [1:0] {
    PH_FETCH  = 2'd0,
    PH_DECODE = 2'd1,
    PH_WAIT   = 2'd2
  } phase_e;

  function automatic logic is_action(input logic [2:0] op);
    return (op == UOP_FWD) || (op == UOP_BACK) || (op == UOP_TURN);
  endfunction
endpackage

// File: rtl/useq_rom.sv
module useq_rom #(
  parameter int ADDR_W = 3,
  parameter int ARG_W  = 8
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] addr,
  output logic [2:0]        op_q,
  output logic [ARG_W-1:0]  arg_q,
  output logic [ADDR_W-1:0] tgt_q
);
  import useq_pkg::*;

  logic [2:0]        op_c;
  logic [ARG_W-1:0]  arg_c;
  logic [ADDR_W-1:0] tgt_c;

  // Patrol program; unused addresses jump back to 0.
  always_comb begin
    op_c  = UOP_JUMP;
    arg_c = '0;
    tgt_c = '0;
    case (int'(addr))
      0: begin op_c = UOP_FWD;      arg_c = ARG_W'(35); end
      1: begin op_c = UOP_BR_CLEAR; tgt_c = ADDR_W'(0); end
      2: begin op_c = UOP_BACK;     arg_c = ARG_W'(10); end
      3: begin op_c = UOP_TURN;     arg_c = ARG_W'(90); end
      4: begin op_c = UOP_JUMP;     tgt_c = ADDR_W'(1); end
      default: ;
    endcase
  end

  // Registered read, as a synchronous ROM.
  always_ff @(posedge clk) begin
    op_q  <= op_c;
    arg_q <= arg_c;
    tgt_q <= tgt_c;
  end
endmodule

// File: rtl/useq_next.sv
module useq_next #(
  parameter int ADDR_W = 3
) (
  input  logic [ADDR_W-1:0] cur,
  input  logic [2:0]        op,
  input  logic [ADDR_W-1:0] tgt,
  input  logic              cond,
  output logic [ADDR_W-1:0] nxt
);
  import useq_pkg::*;

  logic take;

  always_comb begin
    take = (op == UOP_JUMP) || ((op == UOP_BR_CLEAR) && cond);
    nxt  = take ? tgt : cur + ADDR_W'(1);
  end
endmodule

// File: rtl/useq_ctrl.sv
module useq_ctrl #(
  parameter int ADDR_W = 3,
  parameter int ARG_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              path_clear,
  input  logic              act_done,
  output logic              act_stb,
  output logic [2:0]        act_kind,
  output logic [ARG_W-1:0]  act_arg,
  output logic [ADDR_W-1:0] upc
);
  import useq_pkg::*;

  phase_e            phase;
  logic [2:0]        w_op;
  logic [ARG_W-1:0]  w_arg;
  logic [ADDR_W-1:0] w_tgt;
  logic [ADDR_W-1:0] nxt;

  useq_rom #(.ADDR_W(ADDR_W), .ARG_W(ARG_W)) u_rom (
    .clk(clk), .addr(upc), .op_q(w_op), .arg_q(w_arg), .tgt_q(w_tgt)
  );

  useq_next #(.ADDR_W(ADDR_W)) u_next (
    .cur(upc), .op(w_op), .tgt(w_tgt), .cond(path_clear), .nxt(nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_FETCH;
      upc      <= '0;
      act_stb  <= 1'b0;
      act_kind <= '0;
      act_arg  <= '0;
    end else begin
      act_stb <= 1'b0;
      case (phase)
        PH_FETCH: phase <= PH_DECODE;
        PH_DECODE: begin
          if (is_action(w_op)) begin
            act_stb  <= 1'b1;
            act_kind <= w_op;
            act_arg  <= w_arg;
            phase    <= PH_WAIT;
          end else begin
            upc   <= nxt;
            phase <= PH_FETCH;
          end
        end
        PH_WAIT: begin
          if (act_done) begin
            upc   <= nxt;
            phase <= PH_FETCH;
          end
        end
        default: phase <= PH_FETCH;
      endcase
    end
  end

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (upc == '0 && !act_stb)); // R1
  AST_STB_SINGLE: assert property (@(posedge clk) disable iff (rst)
    act_stb |=> !act_stb); // R2
  AST_ACTION_STABLE: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_WAIT && !act_done) |=> ($stable(act_kind) && $stable(act_arg))); // R2
  AST_HOLD_WAIT: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_WAIT && !act_done) |=> ($stable(upc) && !act_stb)); // R3
  AST_BR_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_DECODE && w_op == UOP_BR_CLEAR && path_clear) |=> (upc == $past(w_tgt))); // R4
  AST_BR_FALL: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_DECODE && w_op == UOP_BR_CLEAR && !path_clear) |=> (upc == $past(upc) + ADDR_W'(1))); // R5
  AST_JUMP: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_DECODE && w_op == UOP_JUMP) |=> (upc == $past(w_tgt))); // R6
  AST_DONE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_FETCH && act_done) |=> $stable(upc)); // R7
endmodule

// File: tb/sim_useq_ctrl.sv
module sim_useq_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic path_clear = 1'b0;
  logic act_done = 1'b0;
  logic act_stb;
  logic [2:0] act_kind;
  logic [7:0] act_arg;
  logic [2:0] upc;
  int n_run = 0;
  int n_fail = 0;

  always #10 clk = ~clk; // 50 MHz

  useq_ctrl u0 (
    .clk(clk), .rst(rst), .path_clear(path_clear), .act_done(act_done),
    .act_stb(act_stb), .act_kind(act_kind), .act_arg(act_arg), .upc(upc)
  );

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Wait for a strobe, then check kind, operand, micro-PC and the one-cycle pulse.
  task automatic expect_action(input string req, input int kind, input int arg, input int pc);
    int seen = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (act_stb) begin seen = 1; break; end
    end
    check({req, " strobe"}, seen, 1);
    check({req, " kind"}, act_kind, kind);
    check({req, " arg"}, act_arg, arg);
    check({req, " upc R8"}, upc, pc);
    @(negedge clk);
    check({req, " one-cycle strobe R2"}, act_stb, 0);
  endtask

  task automatic pulse_done();
    act_done = 1'b1;
    @(negedge clk);
    act_done = 1'b0;
  endtask

  // Without completion nothing advances and the outputs hold.
  task automatic check_hold(input string req, input int kind, input int arg, input int pc);
    int extra = 0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (act_stb) extra++;
    end
    check({req, " no new strobe"}, extra, 0);
    check({req, " upc held"}, upc, pc);
    check({req, " kind held"}, act_kind, kind);
    check({req, " arg held"}, act_arg, arg);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 reset upc", upc, 0);
    check("R1 reset strobe", act_stb, 0);
    expect_action("R1 first action", 0, 35, 0);
  endtask

  task automatic t_hold();
    check_hold("R3", 0, 35, 0);
    check_hold("R2 stable", 0, 35, 0);
    path_clear = 1'b1;
    pulse_done();
  endtask

  task automatic t_taken();
    expect_action("R4 branch taken", 0, 35, 0);
    path_clear = 1'b0;
    pulse_done();
  endtask

  task automatic t_fall_and_jump();
    expect_action("R5 fall through", 1, 10, 2);
    pulse_done();
    expect_action("R2 rotate", 2, 90, 3);
    pulse_done();
    expect_action("R6 jump then fall", 1, 10, 2);
    pulse_done();
    expect_action("R6 rotate again", 2, 90, 3);
    path_clear = 1'b1;
    pulse_done();
    expect_action("R6 jump then taken", 0, 35, 0);
    path_clear = 1'b0;
  endtask

  task automatic t_done_ignored();
    act_done = 1'b1;
    repeat (4) @(negedge clk);
    act_done = 1'b0;
    expect_action("R7 next action", 1, 10, 2);
    check_hold("R7 not completed", 1, 10, 2);
    pulse_done();
    expect_action("R7 resumes", 2, 90, 3);
  endtask

  initial begin
    t_reset();
    t_hold();
    t_taken();
    t_fall_and_jump();
    t_done_ignored();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule